// File: doc/BRIEF.md
# Serial HDLC Frame Sender with Collision Lockout

This block turns bytes queued by a host into a bit-serial HDLC frame on a shared signalling line. A frame is an opening flag, the queued bytes, a 16-bit frame check sequence and a closing flag. The payload and the check sequence are zero-stuffed. When no frame is on the line, the output is held at constant one. The line advances one bit for each single-cycle `bit_en` strobe. The strobe comes from the line timing logic outside the block. Bytes enter through a small internal FIFO. The host drives three command pulses: start, end-of-message and transmitter reset.

If the line interface reports a collision while a frame is on the line, the frame is dropped at once and the output returns to ones. A collision interrupt pulses, and the sender locks. While locked it ignores further bytes and start commands. The reset command flushes the FIFO, pulses a FIFO-ready interrupt and returns the block to idle. The host must then reload the frame and start it again. A frame that ends normally pulses a completion interrupt.

The control is a six-state machine:
- `S_IDLE`: the line outputs ones. The first strobe after a start or end command moves to `S_OPEN`.
- `S_OPEN`: sends the flag. After its eighth bit the machine moves to `S_BODY` if a byte is queued, to `S_FCS` if the FIFO is empty but the end is marked, and back to `S_IDLE` otherwise.
- `S_BODY`: sends payload bytes. At each byte boundary the same three-way choice is made.
- `S_FCS`: sends the two check bytes, then moves to `S_CLOSE`.
- `S_CLOSE`: sends the closing flag, then returns to `S_IDLE` and pulses completion.
- `S_LOCK`: entered from any sending state on a collision. Only the reset command leaves it, back to `S_IDLE`.

The reset command forces `S_IDLE` from every state.

Top module: `hdlc_tx_abort`

## Requirements
- R1: Out of reset, between frames, and after a frame is abandoned, `txd` is constant 1. Reset leaves every interrupt low and `fifo_full` low.
- R2: A frame starts with the flag 0x7E and ends with the flag 0x7E, each sent LSB first with no zero insertion. Payload bytes are sent in FIFO order, each LSB first.
- R3: Within the payload and check-sequence bits, a 0 is inserted after every run of five consecutive 1s. This also applies when the run ends on the last check bit, just before the closing flag.
- R4: The check sequence is CRC-ITU-T (x^16+x^12+x^5+1) over the payload, preset to 0xFFFF and reflected. It is complemented and sent low byte first, each byte LSB first. The payload 0x31..0x39 gives the bytes 0x6E then 0x90. An empty payload gives 0x00, 0x00.
- R5: `cmd_end` marks the current FIFO contents as the whole frame and also starts it. Once the last bit of the closing flag is sent, `irq_done` is high for exactly one cycle, once per frame.
- R6: A frame started with `cmd_start` whose FIFO runs empty at a byte boundary with no end mark is abandoned. The line goes to ones and `irq_done` does not pulse.
- R7: `col_in` high during a sending state pulses `irq_col` for one cycle. From the next cycle `txd` is 1, and that frame never raises `irq_done`. `col_in` in `S_IDLE` has no effect.
- R8: While locked after a collision, `txd` stays 1. Start commands, end commands and byte writes are ignored.
- R9: `cmd_reset` flushes the FIFO, returns the block to `S_IDLE` and pulses `irq_ready` in the following cycle. A frame loaded afterwards contains only the new bytes.
- R10: The FIFO holds `FIFO_DEPTH` bytes. `fifo_full` is high while it holds that many, and writes while it is full are dropped.
- R11: `txd` and the frame position change only on a `bit_en` strobe, a collision or a reset command. The first flag bit appears on the second strobe after the start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe that advances the line by one bit |
| wr_en | input | 1 | Write `wr_data` into the FIFO |
| wr_data | input | 8 | Frame byte |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| cmd_start | input | 1 | Start a frame, more bytes may follow |
| cmd_end | input | 1 | Mark the end of the message and start the frame if idle |
| cmd_reset | input | 1 | Transmitter reset: flush, unlock, go idle |
| col_in | input | 1 | Collision indication from the line interface |
| txd | output | 1 | Serial line data |
| irq_done | output | 1 | One-cycle pulse when a frame completes |
| irq_col | output | 1 | One-cycle pulse when a collision aborts a frame |
| irq_ready | output | 1 | One-cycle pulse when the FIFO is ready after a reset |

## Verification
A line bit is registered on the edge that sees `bit_en`. The bench drives each strobe for one cycle from a falling edge and samples `txd` on the next falling edge. It captures one bit per strobe and compares the captured stream against a frame it builds itself: flags, zero insertion and a bytewise CRC. `irq_done` is set on the same edge as the last closing-flag bit. `irq_col` and `irq_ready` follow their cause by one cycle. The bench counts these pulses at falling edges and checks the counts one cycle after the triggering input has been released, so a pulse and its check never fall on the same edge.

// File: rtl/hdlc_txa_pkg.sv
package hdlc_txa_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_BODY,
        S_FCS,
        S_CLOSE,
        S_LOCK
    } txa_state_e;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam int          STUFF_RUN  = 5;

endpackage

// File: rtl/txa_fifo.sv
module txa_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = AW + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr && !flush) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            if (do_wr && !do_rd) begin
                count <= count + 1'b1;
            end else if (do_rd && !do_wr) begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/txa_crc_step.sv
module txa_crc_step #(
    parameter logic [15:0] POLY = 16'h8408
) (
    input  logic [15:0] crc_in,
    input  logic        bit_in,
    output logic [15:0] crc_out
);
    logic fb;
    assign fb      = crc_in[0] ^ bit_in;
    assign crc_out = {1'b0, crc_in[15:1]} ^ (fb ? POLY : 16'h0000);
endmodule

// File: rtl/hdlc_tx_abort.sv
module hdlc_tx_abort
    import hdlc_txa_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fifo_full,
    input  logic       cmd_start,
    input  logic       cmd_end,
    input  logic       cmd_reset,
    input  logic       col_in,
    output logic       txd,
    output logic       irq_done,
    output logic       irq_col,
    output logic       irq_ready
);
    localparam logic [2:0] RUN_LIM = 3'(STUFF_RUN);

    txa_state_e  state, state_nx;
    logic [7:0]  sh;
    logic [2:0]  bcnt;
    logic [2:0]  ones;
    logic [15:0] crc, crc_nx;
    logic [7:0]  fcs_hi;
    logic        fcs_second;
    logic        go;
    logic        end_mark;
    logic        in_lock;

    logic        fifo_empty, fifo_rd;
    logic [7:0]  fifo_q;
    logic        sending, abort_col, stuff_now, byte_last;

    assign sending   = (state == S_OPEN) || (state == S_BODY) ||
                       (state == S_FCS)  || (state == S_CLOSE);
    assign abort_col = sending && col_in && !cmd_reset;
    assign stuff_now = ((state == S_BODY) || (state == S_FCS) ||
                        (state == S_CLOSE)) && (ones == RUN_LIM);
    assign byte_last = (bcnt == 3'd7) && !stuff_now;
    assign in_lock   = (state == S_LOCK);

    assign fifo_rd = bit_en && !cmd_reset && !abort_col && !fifo_empty &&
                     (((state == S_OPEN) && (bcnt == 3'd7)) ||
                      ((state == S_BODY) && byte_last));

    txa_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cmd_reset),
        .wr_en   (wr_en && !in_lock),
        .wr_data (wr_data),
        .rd_en   (fifo_rd),
        .rd_data (fifo_q),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    txa_crc_step #(.POLY(CRC_POLY_R)) u_crc (
        .crc_in  (crc),
        .bit_in  (sh[0]),
        .crc_out (crc_nx)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cmd_reset) begin
            state_nx = S_IDLE;
        end else if (abort_col) begin
            state_nx = S_LOCK;
        end else begin
            unique case (state)
                S_IDLE:  if (bit_en && go) state_nx = S_OPEN;
                S_OPEN:  if (bit_en && bcnt == 3'd7)
                             state_nx = !fifo_empty ? S_BODY :
                                        (end_mark ? S_FCS : S_IDLE);
                S_BODY:  if (bit_en && byte_last)
                             state_nx = !fifo_empty ? S_BODY :
                                        (end_mark ? S_FCS : S_IDLE);
                S_FCS:   if (bit_en && byte_last && fcs_second)
                             state_nx = S_CLOSE;
                S_CLOSE: if (bit_en && byte_last) state_nx = S_IDLE;
                S_LOCK:  state_nx = S_LOCK;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd        <= 1'b1;
            irq_done   <= 1'b0;
            irq_col    <= 1'b0;
            irq_ready  <= 1'b0;
            sh         <= '0;
            bcnt       <= '0;
            ones       <= '0;
            crc        <= CRC_PRESET;
            fcs_hi     <= '0;
            fcs_second <= 1'b0;
            go         <= 1'b0;
            end_mark   <= 1'b0;
        end else begin
            irq_done  <= 1'b0;
            irq_col   <= 1'b0;
            irq_ready <= 1'b0;
            if (cmd_reset) begin
                txd       <= 1'b1;
                go        <= 1'b0;
                end_mark  <= 1'b0;
                irq_ready <= 1'b1;
            end else if (abort_col) begin
                txd      <= 1'b1;
                go       <= 1'b0;
                end_mark <= 1'b0;
                irq_col  <= 1'b1;
            end else begin
                if ((state == S_IDLE) && (cmd_start || cmd_end)) begin
                    go <= 1'b1;
                end
                if (cmd_end && ((state == S_IDLE) || (state == S_OPEN) ||
                                (state == S_BODY))) begin
                    end_mark <= 1'b1;
                end
                if (bit_en) begin
                    unique case (state)
                        S_IDLE: begin
                            txd <= 1'b1;
                            if (go) begin
                                sh         <= FLAG_BYTE;
                                bcnt       <= '0;
                                ones       <= '0;
                                crc        <= CRC_PRESET;
                                fcs_second <= 1'b0;
                                go         <= 1'b0;
                            end
                        end
                        S_OPEN: begin
                            txd  <= sh[0];
                            sh   <= sh >> 1;
                            bcnt <= bcnt + 3'd1;
                            if (bcnt == 3'd7) begin
                                if (!fifo_empty) begin
                                    sh <= fifo_q;
                                end else if (end_mark) begin
                                    sh     <= ~crc[7:0];
                                    fcs_hi <= ~crc[15:8];
                                end
                            end
                        end
                        S_BODY: begin
                            if (stuff_now) begin
                                txd  <= 1'b0;
                                ones <= '0;
                            end else begin
                                txd  <= sh[0];
                                crc  <= crc_nx;
                                ones <= sh[0] ? ones + 3'd1 : 3'd0;
                                sh   <= sh >> 1;
                                bcnt <= bcnt + 3'd1;
                                if (bcnt == 3'd7) begin
                                    if (!fifo_empty) begin
                                        sh <= fifo_q;
                                    end else if (end_mark) begin
                                        sh     <= ~crc_nx[7:0];
                                        fcs_hi <= ~crc_nx[15:8];
                                    end
                                end
                            end
                        end
                        S_FCS: begin
                            if (stuff_now) begin
                                txd  <= 1'b0;
                                ones <= '0;
                            end else begin
                                txd  <= sh[0];
                                ones <= sh[0] ? ones + 3'd1 : 3'd0;
                                sh   <= sh >> 1;
                                bcnt <= bcnt + 3'd1;
                                if (bcnt == 3'd7) begin
                                    if (!fcs_second) begin
                                        sh         <= fcs_hi;
                                        fcs_second <= 1'b1;
                                    end else begin
                                        sh <= FLAG_BYTE;
                                    end
                                end
                            end
                        end
                        S_CLOSE: begin
                            if (stuff_now) begin
                                txd  <= 1'b0;
                                ones <= '0;
                            end else begin
                                txd  <= sh[0];
                                sh   <= sh >> 1;
                                bcnt <= bcnt + 3'd1;
                                if (bcnt == 3'd7) begin
                                    irq_done <= 1'b1;
                                    end_mark <= 1'b0;
                                end
                            end
                        end
                        S_LOCK: txd <= 1'b1;
                        default: txd <= 1'b1;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_abort_chk.sv
module hdlc_tx_abort_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic col_in,
    input logic cmd_reset,
    input logic txd,
    input logic irq_done,
    input logic irq_col,
    input logic irq_ready,
    input logic in_lock
);
    // R11: line only moves on a strobe, collision or reset command
    p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_en) && !$past(col_in) && !$past(cmd_reset)) |-> $stable(txd));

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R7: collision drives the line high and never coincides with completion
    p_col_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_col |-> (txd && !irq_done));

    // R7: collision interrupt is a single-cycle pulse
    p_col_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_col |=> !irq_col);

    // R8: locked sender holds the line at one
    p_lock_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_lock |-> txd);

    // R9: reset command is followed by the ready pulse
    p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> irq_ready);
endmodule

bind hdlc_tx_abort hdlc_tx_abort_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .col_in    (col_in),
    .cmd_reset (cmd_reset),
    .txd       (txd),
    .irq_done  (irq_done),
    .irq_col   (irq_col),
    .irq_ready (irq_ready),
    .in_lock   (in_lock)
);

// File: tb/hdlc_tx_abort_test.sv
module hdlc_tx_abort_test;
    localparam int DEPTH = 16;
    localparam int CAP   = 1024;

    typedef struct packed {
        logic [3:0]  len;
        logic [71:0] data;
        logic        use_end;
        logic [15:0] fcs_fix;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 72'hA5,                 1'b1, 16'h0000},
        '{4'd2, 72'hFFFF,               1'b1, 16'h0000},
        '{4'd9, 72'h393837363534333231, 1'b1, 16'h906E},
        '{4'd3, 72'hF83F7E,             1'b1, 16'h0000},
        '{4'd0, 72'h0,                  1'b1, 16'h0000},
        '{4'd2, 72'h55AA,               1'b0, 16'h0000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_start = 1'b0, cmd_end = 1'b0, cmd_reset = 1'b0, col_in = 1'b0;
    logic       fifo_full, txd, irq_done, irq_col, irq_ready;

    int tests = 0, fails = 0;
    int done_cnt = 0, col_cnt = 0, rdy_cnt = 0;
    bit strobing = 1'b0, finished = 1'b0;
    logic cap [CAP];
    int   capn = 0;
    logic expb [CAP];
    int   expn = 0;
    int   m_ones = 0;

    always #10 clk = ~clk;

    hdlc_tx_abort #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en),
        .wr_data(wr_data), .fifo_full(fifo_full), .cmd_start(cmd_start),
        .cmd_end(cmd_end), .cmd_reset(cmd_reset), .col_in(col_in),
        .txd(txd), .irq_done(irq_done), .irq_col(irq_col), .irq_ready(irq_ready)
    );

    always @(negedge clk) begin
        if (irq_done)  done_cnt++;
        if (irq_col)   col_cnt++;
        if (irq_ready) rdy_cnt++;
    end

    always begin
        @(negedge clk);
        if (strobing) begin
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            if (capn < CAP) cap[capn] = txd;
            capn = capn + 1;
            @(negedge clk);
            @(negedge clk);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) cmd_start = 1'b1;
        if (which == 1) cmd_end   = 1'b1;
        if (which == 2) cmd_reset = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_end = 1'b0; cmd_reset = 1'b0;
    endtask

    task automatic run_slots(input int n);
        capn = 0;
        strobing = 1'b1;
        while (capn < n) @(negedge clk);
        strobing = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic push(input logic b, input bit stuff_on);
        expb[expn] = b; expn++;
        if (stuff_on) begin
            m_ones = b ? m_ones + 1 : 0;
            if (m_ones == 5) begin
                expb[expn] = 1'b0; expn++; m_ones = 0;
            end
        end
    endtask

    task automatic push_byte(input logic [7:0] v, input bit stuff_on);
        for (int k = 0; k < 8; k++) push(v[k], stuff_on);
    endtask

    // expected line image: flag, stuffed payload [+fcs, flag]
    task automatic build(input int len, input logic [8*DEPTH-1:0] data,
                         input bit closed, input logic [15:0] fcs_fix);
        logic [15:0] c;
        logic [15:0] f;
        expn = 0; m_ones = 0; c = 16'hFFFF;
        push_byte(8'h7E, 1'b0);
        for (int i = 0; i < len; i++) begin
            push_byte(data[8*i +: 8], 1'b1);
            c = c ^ {8'h00, data[8*i +: 8]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        if (closed) begin
            f = (fcs_fix != 16'h0000) ? fcs_fix : ~c;
            push_byte(f[7:0], 1'b1);
            push_byte(f[15:8], 1'b1);
            push_byte(8'h7E, 1'b0);
        end
    endtask

    // mismatches between captured line and expected image, plus trailing ones
    task automatic compare(output int mism, output int tail_bad);
        int s = -1;
        mism = 0; tail_bad = 0;
        for (int i = 0; i < capn && i < CAP; i++) begin
            if (s < 0 && cap[i] == 1'b0) s = i;
        end
        if (s < 0) begin
            mism = expn;
        end else begin
            for (int k = 0; k < expn; k++) begin
                if (s + k >= capn || cap[s + k] !== expb[k]) mism++;
            end
            for (int k = 0; k < 8; k++) begin
                if (s + expn + k >= capn || cap[s + expn + k] !== 1'b1) tail_bad++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int mism, tail, d0, c0, r0, ci, bad;
        logic [8*DEPTH-1:0] big;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 txd in reset", int'(txd), 1);
        chk("R1 irqs in reset", int'(irq_done | irq_col | irq_ready), 0);
        chk("R10 fifo_full in reset", int'(fifo_full), 0);
        rst_n = 1'b1;
        // R1: idle fill
        run_slots(30);
        bad = 0;
        for (int i = 0; i < 30; i++) if (cap[i] !== 1'b1) bad++;
        chk("R1 idle ones", bad, 0);

        // vector table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < VECS[v].len; i++) write_byte(VECS[v].data[8*i +: 8]);
            d0 = done_cnt;
            pulse(VECS[v].use_end ? 1 : 0);
            run_slots(220);
            build(int'(VECS[v].len), {56'h0, VECS[v].data}, VECS[v].use_end, VECS[v].fcs_fix);
            compare(mism, tail);
            chk($sformatf("R2/R3/R4 line image vec%0d", v), mism, 0);
            chk($sformatf("R1/R6 trailing ones vec%0d", v), tail, 0);
            chk($sformatf("R5/R6 done pulses vec%0d", v), done_cnt - d0, VECS[v].use_end ? 1 : 0);
        end

        // R11: no progress without strobes
        write_byte(8'hC3);
        d0 = done_cnt;
        pulse(1);
        repeat (50) @(negedge clk);
        chk("R11 txd without strobe", int'(txd), 1);
        chk("R11 no done without strobe", done_cnt - d0, 0);
        run_slots(100);
        build(1, {{(8*DEPTH-8){1'b0}}, 8'hC3}, 1'b1, 16'h0);
        compare(mism, tail);
        chk("R11 frame after delayed strobes", mism, 0);

        // R10: overfill
        for (int i = 0; i < DEPTH + 2; i++) write_byte(8'(i * 7 + 1));
        chk("R10 fifo_full when full", int'(fifo_full), 1);
        for (int i = 0; i < DEPTH; i++) big[8*i +: 8] = 8'(i * 7 + 1);
        pulse(1);
        run_slots(280);
        build(DEPTH, big, 1'b1, 16'h0);
        compare(mism, tail);
        chk("R10 extra writes dropped", mism, 0);

        // R7: collision abort
        c0 = col_cnt;
        pulse(0);
        ci = 0;
        for (int i = 0; i < 4; i++) write_byte(8'h11 * (i + 1));
        d0 = col_cnt;
        chk("R7 col_in idle no effect pre", d0 - c0, 0);
        @(negedge clk); col_in = 1'b1; @(negedge clk); col_in = 1'b0;
        @(negedge clk);
        chk("R7 col_in in idle ignored", col_cnt - c0, 0);
        d0 = done_cnt;
        capn = 0; strobing = 1'b1;
        while (capn < 20) @(negedge clk);
        col_in = 1'b1; ci = capn;
        @(negedge clk); col_in = 1'b0;
        @(negedge clk);
        chk("R7 collision interrupt", col_cnt - c0, 1);
        chk("R7 line high after collision", int'(txd), 1);
        while (capn < ci + 40) @(negedge clk);
        strobing = 1'b0;
        bad = 0;
        for (int i = ci + 1; i < capn; i++) if (cap[i] !== 1'b1) bad++;
        chk("R7 ones after abort", bad, 0);

        // R8: locked ignores writes and commands
        write_byte(8'h12); write_byte(8'h34);
        pulse(1);
        run_slots(40);
        bad = 0;
        for (int i = 0; i < 40; i++) if (cap[i] !== 1'b1) bad++;
        chk("R8 locked line ones", bad, 0);
        chk("R7/R8 no done while locked", done_cnt - d0, 0);

        // R9: reset, ready, flush
        r0 = rdy_cnt;
        pulse(2);
        @(negedge clk);
        chk("R9 ready pulse", rdy_cnt - r0, 1);
        write_byte(8'h5A);
        pulse(1);
        run_slots(100);
        build(1, {{(8*DEPTH-8){1'b0}}, 8'h5A}, 1'b1, 16'h0);
        compare(mism, tail);
        chk("R9 only new byte after reset", mism, 0);
        chk("R9 done after reload", done_cnt - d0, 1);

        summary();
    end
endmodule